// File: doc/BRIEF.md
# Serial NOR Flash Erase Sequencer

This block carries out one erase of an external serial NOR flash over a single-data-line SPI port. The requester supplies a start address, a two-bit size code and an address-width select, and pulses `start`. The sequencer checks the request and then runs three kinds of chip-select frames in turn. The first is a write-enable frame. The second is the erase command, with its address where the size needs one. The last is a repeated status-read frame that continues until the flash reports that it is idle. A one-cycle `done` pulse marks the end of the operation, and `busy` falls in the same cycle.

The controller is a single enumerated state machine with seven states. `ST_IDLE` waits for a request. When a valid request arrives, it moves to `ST_WREN`, which sends the write-enable byte. When that frame ends, it moves to `ST_GAP_WREN`, which holds chip select high. From there it goes to `ST_ERASE`, which sends the opcode and any address bytes. When that frame ends, it moves to `ST_GAP_ERASE`, and then to `ST_POLL`, which sends the status opcode and reads one byte. From `ST_POLL` it goes to `ST_GAP_POLL`. When that gap expires, it returns to `ST_POLL` if the busy flag was set, or to `ST_IDLE` with a `done` pulse if it was clear. A byte shifter below the state machine produces the serial clock from a half-period divider and moves one byte per launch.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `busy`, `done`, `reject` and `sck` are 0 and `cs_n` is 1.
- R2: Every accepted request first sends a chip-select frame that holds only the byte 0x06.
- R3: Size code 0 selects a 4 KB block erase with opcode 0x20. Size code 1 selects a 64 KB block erase with opcode 0xD8. In both cases the opcode is followed in the same frame by the address.
- R4: Size code 2 sends opcode 0xC7 alone in its frame, and the low two address bits are not checked for this code.
- R5: With `addr_wide`=0 the address is `erase_addr[23:0]` as 3 bytes. With `addr_wide`=1 it is `erase_addr[31:0]` as 4 bytes. Both are sent most significant byte first.
- R6: A block request with `erase_addr[1:0]`≠0, or any request with size code 3, is refused. `reject` pulses for one cycle, no frame is sent and `busy` stays 0.
- R7: After the erase frame, the block sends a 2-byte frame of 0x05 followed by one read byte. It repeats that frame while bit 0 of the read byte is 1, and other bits of that byte have no effect.
- R8: Between two frames of one operation, `cs_n` stays high for at least `GAP_CYCLES` clock cycles.
- R9: SPI mode 0 is used. `sck` idles low and is low whenever `cs_n` is high. `mosi` only changes while `sck` is low, and `miso` is sampled as `sck` rises. Bits are sent most significant bit first.
- R10: `done` pulses for exactly one cycle once a poll returns bit 0 clear and its gap has elapsed, and `busy` is 0 in that cycle. A `start` while `busy` is 1 has no effect on the frames sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| erase_addr | input | 32 | Erase start address |
| size_code | input | 2 | 0: 4 KB, 1: 64 KB, 2: whole device, 3: refused |
| addr_wide | input | 1 | 0: 3 address bytes, 1: 4 address bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| reject | output | 1 | One-cycle pulse for a refused request |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The poll loop is the path hardest to reach from the ports, because it only runs again when the flash returns a status byte with bit 0 set. The bench therefore contains a behavioural flash. This model decodes every frame and answers the status opcode with a busy byte for a chosen number of polls, then with an idle byte. Both answers carry bit 1 set, which shows that only bit 0 counts. A second hard case is a `start` arriving mid-operation. To cover it, the bench injects a conflicting request while frames are in flight and confirms that the captured frame stream still matches the first request.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREN,
        ST_GAP_WREN,
        ST_ERASE,
        ST_GAP_ERASE,
        ST_POLL,
        ST_GAP_POLL
    } seq_state_t;

    localparam logic [7:0] OP_WREN       = 8'h06;
    localparam logic [7:0] OP_ERASE_4K   = 8'h20;
    localparam logic [7:0] OP_ERASE_64K  = 8'hD8;
    localparam logic [7:0] OP_ERASE_CHIP = 8'hC7;
    localparam logic [7:0] OP_READ_STAT  = 8'h05;

    localparam logic [1:0] SZ_4K   = 2'd0;
    localparam logic [1:0] SZ_64K  = 2'd1;
    localparam logic [1:0] SZ_CHIP = 2'd2;

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    localparam int DW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);

    logic [DW-1:0] div_cnt;
    logic [2:0]    bit_cnt;
    logic [7:0]    tx_q;
    logic [7:0]    rx_q;
    logic          sck_q;
    logic          active;
    logic          tick;

    assign tick    = (div_cnt == DW'(HALF_DIV - 1));
    assign sck     = sck_q;
    assign mosi    = tx_q[7];
    assign rx_byte = rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt   <= '0;
            bit_cnt   <= '0;
            tx_q      <= '0;
            rx_q      <= '0;
            sck_q     <= 1'b0;
            active    <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (launch && !active) begin
                active  <= 1'b1;
                tx_q    <= tx_byte;
                bit_cnt <= 3'd7;
                div_cnt <= '0;
                sck_q   <= 1'b0;
            end else if (active) begin
                if (tick) begin
                    div_cnt <= '0;
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                        rx_q  <= {rx_q[6:0], miso};
                    end else begin
                        sck_q <= 1'b0;
                        if (bit_cnt == 3'd0) begin
                            active    <= 1'b0;
                            byte_done <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt - 3'd1;
                            tx_q    <= {tx_q[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + DW'(1);
                end
            end
        end
    end

    // R9: data out holds while the clock is high
    p_mosi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q && $past(sck_q)) |-> $stable(mosi));

    // R9: the sequencer never launches into a byte already in flight
    p_no_relaunch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !active);

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int GAP_CYCLES = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] erase_addr,
    input  logic [1:0]  size_code,
    input  logic        addr_wide,
    output logic        busy,
    output logic        done,
    output logic        reject,
    output logic        sck,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso
);
    localparam int GW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);

    seq_state_t    state, next_state;
    logic [2:0]    idx, last_idx, rem_bytes;
    logic          need_launch, launch, wip;
    logic [GW-1:0] gap_cnt;
    logic [7:0]    opcode_q, tx_byte, rx_byte, op_sel;
    logic [31:0]   addr_q, addr_shifted;
    logic          wide_q, done_q, reject_q, byte_done;
    logic          in_frame, next_in_frame, frame_end, gap_end, req_ok;

    spi_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .tx_byte   (tx_byte),
        .miso      (miso),
        .sck       (sck),
        .mosi      (mosi),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    assign in_frame      = (state == ST_WREN) || (state == ST_ERASE) || (state == ST_POLL);
    assign next_in_frame = (next_state == ST_WREN) || (next_state == ST_ERASE) ||
                           (next_state == ST_POLL);
    assign frame_end     = in_frame && byte_done && (idx == last_idx);
    assign gap_end       = (gap_cnt == GW'(GAP_CYCLES - 1));
    assign req_ok        = (size_code == SZ_CHIP) ||
                           (((size_code == SZ_4K) || (size_code == SZ_64K)) &&
                            (erase_addr[1:0] == 2'b00));
    assign rem_bytes     = last_idx - idx;
    assign addr_shifted  = addr_q >> {rem_bytes, 3'b000};
    assign launch        = need_launch && in_frame;

    assign busy   = (state != ST_IDLE);
    assign cs_n   = !in_frame;
    assign done   = done_q;
    assign reject = reject_q;

    always_comb begin
        unique case (size_code)
            SZ_4K:   op_sel = OP_ERASE_4K;
            SZ_64K:  op_sel = OP_ERASE_64K;
            default: op_sel = OP_ERASE_CHIP;
        endcase
    end

    // Next state and byte selection
    always_comb begin
        next_state = state;
        tx_byte    = 8'h00;
        unique case (state)
            ST_IDLE:      if (start && req_ok) next_state = ST_WREN;
            ST_WREN: begin
                tx_byte = OP_WREN;
                if (frame_end) next_state = ST_GAP_WREN;
            end
            ST_GAP_WREN:  if (gap_end) next_state = ST_ERASE;
            ST_ERASE: begin
                tx_byte = (idx == 3'd0) ? opcode_q : addr_shifted[7:0];
                if (frame_end) next_state = ST_GAP_ERASE;
            end
            ST_GAP_ERASE: if (gap_end) next_state = ST_POLL;
            ST_POLL: begin
                tx_byte = (idx == 3'd0) ? OP_READ_STAT : 8'h00;
                if (frame_end) next_state = ST_GAP_POLL;
            end
            ST_GAP_POLL:  if (gap_end) next_state = wip ? ST_POLL : ST_IDLE;
            default:      next_state = ST_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            idx         <= '0;
            last_idx    <= '0;
            need_launch <= 1'b0;
            gap_cnt     <= '0;
            wip         <= 1'b0;
            opcode_q    <= '0;
            addr_q      <= '0;
            wide_q      <= 1'b0;
            done_q      <= 1'b0;
            reject_q    <= 1'b0;
        end else begin
            state    <= next_state;
            done_q   <= (state == ST_GAP_POLL) && gap_end && !wip;
            reject_q <= (state == ST_IDLE) && start && !req_ok;

            if ((state == ST_IDLE) && start && req_ok) begin
                opcode_q <= op_sel;
                addr_q   <= erase_addr;
                wide_q   <= addr_wide;
            end

            if ((next_state == state) && !in_frame && (state != ST_IDLE))
                gap_cnt <= gap_cnt + GW'(1);
            else
                gap_cnt <= '0;

            if (frame_end && (state == ST_POLL))
                wip <= rx_byte[0];

            if (launch) need_launch <= 1'b0;
            if (in_frame && byte_done && !frame_end) begin
                idx         <= idx + 3'd1;
                need_launch <= 1'b1;
            end

            if ((next_state != state) && next_in_frame) begin
                idx         <= '0;
                need_launch <= 1'b1;
                unique case (next_state)
                    ST_ERASE: last_idx <= (opcode_q == OP_ERASE_CHIP) ? 3'd0 :
                                          (wide_q ? 3'd4 : 3'd3);
                    ST_POLL:  last_idx <= 3'd1;
                    default:  last_idx <= 3'd0;
                endcase
            end
        end
    end

    // Checker state: length of the current chip-select high run
    logic [15:0] hi_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                hi_run <= '0;
        else if (!cs_n)            hi_run <= '0;
        else if (hi_run != 16'hFFFF) hi_run <= hi_run + 16'd1;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sck));

    p_reject_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> (!busy && !done));

    p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && $past(busy)) |-> (hi_run >= 16'(GAP_CYCLES)));

    p_sck_framed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cs_n));

    p_request_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> ($stable(opcode_q) && $stable(addr_q)));

endmodule

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 3;

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  size;
        logic        wide;
        logic [3:0]  polls;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [0:NV-1] = '{
        '{32'h0012_3400, 2'd0, 1'b0, 4'd0},
        '{32'hA1B2_C3D4, 2'd1, 1'b1, 4'd2},
        '{32'h0000_0003, 2'd2, 1'b0, 4'd1},
        '{32'h0000_0002, 2'd0, 1'b1, 4'd0},
        '{32'h0000_1000, 2'd3, 1'b0, 4'd0},
        '{32'h77FF_0000, 2'd1, 1'b0, 4'd3},
        '{32'h0000_0101, 2'd1, 1'b1, 4'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [31:0] erase_addr = '0;
    logic [1:0]  size_code = '0;
    logic        addr_wide = 1'b0;
    logic busy, done, reject, sck, cs_n, mosi, miso;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_erase_seq #(.HALF_DIV(2), .GAP_CYCLES(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .erase_addr(erase_addr),
        .size_code(size_code), .addr_wide(addr_wide), .busy(busy), .done(done),
        .reject(reject), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    // Behavioural flash: frame capture and status answers
    logic [7:0] fb [0:127][0:7];
    int fl [0:127];
    int gap_before [0:127];
    int nf = 0;
    int bc = 0;
    int poll_cnt = 0;
    int poll_base = 0;
    int busy_polls = 0;
    int mosi_bad = 0;
    int hi_cnt = 0;
    logic prev_cs = 1'b1;
    logic [7:0] shreg = '0;
    logic [7:0] stat;

    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            if (bc > 0) begin
                fl[nf] = bc / 8;
                if (fb[nf][0] == 8'h05) poll_cnt = poll_cnt + 1;
                nf = nf + 1;
            end
            bc = 0;
        end else begin
            shreg = {shreg[6:0], mosi};
            bc = bc + 1;
            if ((bc % 8) == 0 && (bc / 8) <= 8) fb[nf][bc/8 - 1] = shreg;
        end
    end

    always_comb begin
        stat = ((poll_cnt - poll_base) < busy_polls) ? 8'h03 : 8'h02;
        if (!cs_n && bc >= 8 && bc < 16 && fb[nf][0] == 8'h05)
            miso = stat[7 - (bc % 8)];
        else
            miso = 1'b0;
    end

    always @(mosi) if (sck && !cs_n) mosi_bad = mosi_bad + 1;

    always @(posedge clk) begin
        if (cs_n) hi_cnt <= hi_cnt + 1;
        else begin
            if (prev_cs) gap_before[nf] <= hi_cnt;
            hi_cnt <= 0;
        end
        prev_cs <= cs_n;
    end

    int total = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit vec_ok(vec_t v);
        if (v.size == 2'd2) return 1'b1;
        if (v.size == 2'd3) return 1'b0;
        return v.addr[1:0] == 2'b00;
    endfunction

    function automatic int exp_len(vec_t v);
        if (v.size == 2'd2) return 1;
        return v.wide ? 5 : 4;
    endfunction

    function automatic logic [7:0] exp_byte(vec_t v, int k);
        int n;
        if (k == 0) return (v.size == 2'd0) ? 8'h20 : (v.size == 2'd1) ? 8'hD8 : 8'hC7;
        n = v.wide ? 4 : 3;
        return 8'(v.addr >> (8 * (n - k)));
    endfunction

    task automatic run_op(input vec_t v, input bit disturb);
        int base;
        bit saw_done, saw_rej;
        int cyc;
        base = nf;
        poll_base = poll_cnt;
        busy_polls = int'(v.polls);
        saw_done = 0; saw_rej = 0;
        @(negedge clk);
        erase_addr = v.addr; size_code = v.size; addr_wide = v.wide; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (cyc = 0; cyc < 20000; cyc++) begin
            if (done) begin
                saw_done = 1;
                chk(busy == 1'b0, "R10", "busy with done", busy, 0);
                @(negedge clk);
                chk(done == 1'b0, "R10", "done width", done, 0);
                break;
            end
            if (reject) begin saw_rej = 1; break; end
            if (disturb && cyc == 150) begin
                erase_addr = 32'h0000_0001; size_code = 2'd2; addr_wide = 1'b1; start = 1'b1;
            end else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
        if (!vec_ok(v)) begin
            chk(saw_rej, "R6", "reject pulse", saw_rej, 1);
            chk(nf == base, "R6", "frames on refusal", nf - base, 0);
            chk(busy == 1'b0, "R6", "busy after refusal", busy, 0);
        end else begin
            chk(saw_done && !saw_rej, "R10", "completion", saw_done, 1);
            chk(nf - base == 3 + int'(v.polls), "R7", "frame count", nf - base, 3 + v.polls);
            if (nf - base >= 2) begin
                chk(fl[base] == 1 && fb[base][0] == 8'h06, "R2", "write enable frame",
                    fb[base][0], 8'h06);
                chk(fl[base+1] == exp_len(v), "R5", "erase frame length",
                    fl[base+1], exp_len(v));
                chk(fb[base+1][0] == exp_byte(v, 0), (v.size == 2'd2) ? "R4" : "R3",
                    "erase opcode", fb[base+1][0], exp_byte(v, 0));
                for (int k = 1; k < exp_len(v); k++)
                    chk(fb[base+1][k] == exp_byte(v, k), "R5", "address byte",
                        fb[base+1][k], exp_byte(v, k));
                for (int f = base + 2; f < nf; f++)
                    chk(fl[f] == 2 && fb[f][0] == 8'h05, "R7", "poll frame", fb[f][0], 8'h05);
                for (int f = base + 1; f < nf; f++)
                    chk(gap_before[f] >= GAP, "R8", "chip select gap", gap_before[f], GAP);
            end
        end
        chk(mosi_bad == 0, "R9", "mosi moved with sck high", mosi_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && reject == 0, "R1", "status after reset",
            {busy, done, reject}, 0);
        chk(cs_n == 1'b1 && sck == 1'b0, "R1", "pins after reset", {cs_n, sck}, 2'b10);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n == 1'b1 && sck == 1'b0 && busy == 1'b0, "R9", "idle pins",
            {cs_n, sck, busy}, 3'b100);

        for (int i = 0; i < NV; i++) run_op(VECS[i], 1'b0);

        // R10: a conflicting request mid-operation must not alter the frames
        run_op(VECS[1], 1'b1);

        // R6: refusal followed at once by a valid chip erase
        run_op(VECS[4], 1'b0);
        run_op(VECS[2], 1'b0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total + 1);
        $finish;
    end

endmodule